// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter. A start command begins a conversion. Each conversion has a sample phase, during which the input capacitance is charged. Ten compare steps follow. Each step drives a trial code to the capacitor array, and the comparator answer sampled at the end of the step decides whether the trial bit is kept. The decisions run from the most significant bit down to the least. The finished code is placed in a single result register together with its channel number.

Two 2-bit fields set the timing. One sets the sample length and the other sets the compare-step length. Each field picks a multiplier of 1, 2, 4 or 8. The multiplier scales a base of 16 TCL for the sample phase and 8 TCL for each compare step, where one clock cycle equals 2 TCL. In scan mode the block converts every channel from the programmed one down to channel 0 and keeps busy high for the whole walk.

The block also drives the analog power and calibration controls. A power-off bit turns the analog macro off while the block is idle. A start that arrives while the converter is off wakes it at once, without waiting for the analog to settle. If the off bit is still set when the work ends, the converter goes off again. A settled flag reports when the analog power-up time has passed. A calibration runs on its own after every reset. Raising the off bit during calibration cuts it short for good.

Top module: `sar_adc_seq`

## Requirements
- R1: During reset: busy, sample, bit strobe and result-valid are 0; the result is 0; power-enable is 1; calibration-active is 1; calibration-done and settled are 0.
- R2: After an accepted start, busy is 1 from the next cycle. The sample output is high for exactly 8·2^S cycles per channel, where S is the sample-time field value 0..3.
- R3: Each channel then takes ten compare steps of 4·2^C cycles each, where C is the compare-time field value 0..3. The bit strobe pulses once at the end of each step. Busy is high for N·(8·2^S + 10·4·2^C) consecutive cycles for N channels. Both timing fields are captured at start.
- R4: Bits are decided MSB first. A trial bit is kept when the comparator input is 1 (input at or above the trial code) at the end of its step, so the result equals the analog value. The result and its channel update with a one-cycle valid pulse in the cycle busy falls. The result holds otherwise.
- R5: A start is ignored while busy is high or calibration is active. No extra result appears and busy does not rise.
- R6: With the scan bit set (1), channels run from the programmed channel down to 0. Busy stays high throughout, and one result is produced per channel carrying that channel's number.
- R7: Power-enable is 1 whenever busy is 1. A start while the off bit is set raises power-enable in the same cycle busy rises, with settled still 0.
- R8: While idle, power-enable follows the inverse of the off bit one cycle later. If the off bit is set when the last conversion of a command ends, power-enable falls in the same cycle as busy.
- R9: Settled is 0 while power is off. It rises exactly CLK_MHZ·SETTLE_US cycles after power-enable rises.
- R10: Calibration-active stays high for CAL_CYCLES cycles after reset release, then falls with calibration-done set to 1.
- R11: Setting the off bit during calibration ends calibration-active on the next cycle. Calibration-done then stays 0, even after the off bit clears, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock (one period = 2 TCL) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command pulse |
| off_i | input | 1 | Power-off request level |
| scan_i | input | 1 | Scan mode select |
| chan_i | input | CH_W | Programmed (first) channel |
| stc_i | input | 2 | Sample-time multiplier select |
| ctc_i | input | 2 | Compare-step multiplier select |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial code |
| busy_o | output | 1 | Conversion or scan cycle in progress |
| sample_o | output | 1 | Sample phase active |
| bit_strobe_o | output | 1 | One-cycle pulse per bit decision |
| trial_o | output | RES_BITS | Trial code for the capacitor array |
| chan_o | output | CH_W | Channel currently converted |
| result_o | output | RES_BITS | Last conversion result |
| result_chan_o | output | CH_W | Channel of the last result |
| result_valid_o | output | 1 | Pulse when result updates |
| pwr_en_o | output | 1 | Analog macro power enable |
| settled_o | output | 1 | Power-up time elapsed |
| cal_active_o | output | 1 | Calibration running |
| cal_done_o | output | 1 | Calibration completed |

## Verification
The bench builds the block with CLK_MHZ=1, SETTLE_US=12 and CAL_CYCLES=20. With these values the settle window and a full calibration each last tens of cycles, so the bench can count them exactly and can reset a second time to check the abort case. The timing fields keep their real multipliers. The longest setting, 64 sample cycles plus ten 32-cycle steps, is therefore covered next to the shortest one. Scan walks over up to six channels also fit well inside the run.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_COMPARE = 2'd2
  } phase_e;

  // cycles of one phase: base length in TCL scaled by 2^sel, two TCL per clock
  function automatic int unsigned phase_cycles(int unsigned base_tcl, logic [1:0] sel);
    return (base_tcl << sel) / 2;
  endfunction

  // largest phase in cycles over both bases at the top multiplier
  function automatic int unsigned max_phase_cycles(int unsigned a_tcl, int unsigned b_tcl);
    return phase_cycles((a_tcl > b_tcl) ? a_tcl : b_tcl, 2'd3);
  endfunction

endpackage

// File: rtl/sar_conv_fsm.sv
module sar_conv_fsm
  import sar_seq_pkg::*;
#(
  parameter int unsigned RES_BITS   = 10,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned SAMPLE_TCL = 16,
  parameter int unsigned STEP_TCL   = 8,
  localparam int unsigned BIT_W     = $clog2(RES_BITS),
  localparam int unsigned CNT_W     = $clog2(max_phase_cycles(SAMPLE_TCL, STEP_TCL))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hold_i,
  input  logic             scan_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [1:0]       stc_i,
  input  logic [1:0]       ctc_i,
  output logic             busy_o,
  output logic             busy_d_o,
  output logic             sample_o,
  output logic             step_end_o,
  output logic             last_bit_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic [CH_W-1:0]  chan_o
);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CH_W-1:0]   chan_q;
  logic              scan_q;
  logic [1:0]        stc_q;
  logic [1:0]        ctc_q;
  logic              busy_q;

  logic accept_w;
  logic cnt_zero_w;
  logic step_end_w;
  logic last_bit_w;
  logic more_chan_w;
  logic cycle_done_w;

  function automatic logic [CNT_W-1:0] sample_load(logic [1:0] sel);
    return CNT_W'(phase_cycles(SAMPLE_TCL, sel) - 1);
  endfunction

  function automatic logic [CNT_W-1:0] step_load(logic [1:0] sel);
    return CNT_W'(phase_cycles(STEP_TCL, sel) - 1);
  endfunction

  always_comb begin
    accept_w     = start_i && !busy_q && !hold_i;
    cnt_zero_w   = (cnt_q == '0);
    step_end_w   = (phase_q == PH_COMPARE) && cnt_zero_w;
    last_bit_w   = step_end_w && (bit_q == '0);
    more_chan_w  = scan_q && (chan_q != '0);
    cycle_done_w = last_bit_w && !more_chan_w;
    busy_d_o     = accept_w || (busy_q && !cycle_done_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      chan_q  <= '0;
      scan_q  <= 1'b0;
      stc_q   <= '0;
      ctc_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= busy_d_o;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept_w) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= sample_load(stc_i);
            chan_q  <= chan_i;
            scan_q  <= scan_i;
            stc_q   <= stc_i;
            ctc_q   <= ctc_i;
          end
        end
        PH_SAMPLE: begin
          if (cnt_zero_w) begin
            phase_q <= PH_COMPARE;
            cnt_q   <= step_load(ctc_q);
            bit_q   <= BIT_W'(RES_BITS - 1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_COMPARE: begin
          if (!cnt_zero_w) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (bit_q != '0) begin
            bit_q <= bit_q - BIT_W'(1);
            cnt_q <= step_load(ctc_q);
          end else if (more_chan_w) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= sample_load(stc_q);
            chan_q  <= chan_q - CH_W'(1);
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign sample_o   = (phase_q == PH_SAMPLE);
  assign step_end_o = step_end_w;
  assign last_bit_o = last_bit_w;
  assign bit_idx_o  = bit_q;
  assign chan_o     = chan_q;

  AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> busy_q); // R2
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(stc_q) && $stable(ctc_q))); // R3
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i)); // R5
  AST_SCAN_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(chan_q)) |-> (chan_q == $past(chan_q) - CH_W'(1))); // R6

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned CH_W     = 4,
  localparam int unsigned BIT_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                step_end_i,
  input  logic                last_bit_i,
  input  logic [BIT_W-1:0]    bit_idx_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic [RES_BITS-1:0] result_o,
  output logic [CH_W-1:0]     result_chan_o,
  output logic                result_valid_o
);

  logic [RES_BITS-1:0] sar_q;
  logic [RES_BITS-1:0] decided_w;
  logic [RES_BITS-1:0] result_q;
  logic [CH_W-1:0]     rchan_q;
  logic                valid_q;

  // trial sets the bit under test; decided replaces it with the comparator answer
  always_comb begin
    for (int i = 0; i < int'(RES_BITS); i++) begin
      trial_o[i]   = sar_q[i] | (bit_idx_i == BIT_W'(i));
      decided_w[i] = (bit_idx_i == BIT_W'(i)) ? cmp_i : sar_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q    <= '0;
      result_q <= '0;
      rchan_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (clear_i) begin
        sar_q <= '0;
      end else if (step_end_i) begin
        sar_q <= decided_w;
      end
      valid_q <= last_bit_i;
      if (last_bit_i) begin
        result_q <= decided_w;
        rchan_q  <= chan_i;
      end
    end
  end

  assign result_o       = result_q;
  assign result_chan_o  = rchan_q;
  assign result_valid_o = valid_q;

  AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(last_bit_i)); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_o)); // R4

endmodule

// File: rtl/sar_power_ctl.sv
module sar_power_ctl #(
  parameter int unsigned SETTLE_CYC = 2000,
  localparam int unsigned SET_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_i,
  input  logic busy_i,
  input  logic busy_d_i,
  output logic pwr_en_o,
  output logic settled_o
);

  logic             pwr_q;
  logic [SET_W-1:0] set_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q     <= 1'b1;
      set_cnt_q <= '0;
    end else begin
      pwr_q <= !off_i || busy_d_i;
      if (!pwr_q) begin
        set_cnt_q <= '0;
      end else if (set_cnt_q != SET_W'(SETTLE_CYC)) begin
        set_cnt_q <= set_cnt_q + SET_W'(1);
      end
    end
  end

  assign pwr_en_o  = pwr_q;
  assign settled_o = pwr_q && (set_cnt_q == SET_W'(SETTLE_CYC));

  AST_PWR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> pwr_en_o); // R7
  AST_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_i) && $past(off_i)) |-> !pwr_en_o); // R8
  AST_SETTLE_AFTER_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled_o) |-> $past(pwr_en_o)); // R9

endmodule

// File: rtl/sar_cal_ctl.sv
module sar_cal_ctl #(
  parameter int unsigned CAL_CYCLES = 512,
  localparam int unsigned CAL_W     = $clog2(CAL_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_i,
  output logic cal_active_o,
  output logic cal_done_o
);

  logic             active_q;
  logic             done_q;
  logic [CAL_W-1:0] cal_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b1;
      done_q    <= 1'b0;
      cal_cnt_q <= '0;
    end else if (active_q) begin
      if (off_i) begin
        active_q <= 1'b0;
      end else if (cal_cnt_q == CAL_W'(CAL_CYCLES - 1)) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        cal_cnt_q <= cal_cnt_q + CAL_W'(1);
      end
    end
  end

  assign cal_active_o = active_q;
  assign cal_done_o   = done_q;

  AST_CAL_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_active_o && cal_done_o)); // R10
  AST_CAL_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_active_o |=> !cal_active_o); // R11
  AST_CAL_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cal_active_o) && $past(off_i)) |-> !cal_done_o); // R11

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int unsigned RES_BITS   = 10,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned SAMPLE_TCL = 16,
  parameter int unsigned STEP_TCL   = 8,
  parameter int unsigned CLK_MHZ    = 40,
  parameter int unsigned SETTLE_US  = 50,
  parameter int unsigned CAL_CYCLES = 512,
  localparam int unsigned BIT_W      = $clog2(RES_BITS),
  localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                off_i,
  input  logic                scan_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic [1:0]          stc_i,
  input  logic [1:0]          ctc_i,
  input  logic                cmp_i,
  output logic                busy_o,
  output logic                sample_o,
  output logic                bit_strobe_o,
  output logic [RES_BITS-1:0] trial_o,
  output logic [CH_W-1:0]     chan_o,
  output logic [RES_BITS-1:0] result_o,
  output logic [CH_W-1:0]     result_chan_o,
  output logic                result_valid_o,
  output logic                pwr_en_o,
  output logic                settled_o,
  output logic                cal_active_o,
  output logic                cal_done_o
);

  logic             busy_w;
  logic             busy_d_w;
  logic             sample_w;
  logic             step_end_w;
  logic             last_bit_w;
  logic [BIT_W-1:0] bit_idx_w;
  logic [CH_W-1:0]  chan_w;
  logic             cal_active_w;

  sar_cal_ctl #(
    .CAL_CYCLES(CAL_CYCLES)
  ) u_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .off_i       (off_i),
    .cal_active_o(cal_active_w),
    .cal_done_o  (cal_done_o)
  );

  sar_conv_fsm #(
    .RES_BITS  (RES_BITS),
    .CH_W      (CH_W),
    .SAMPLE_TCL(SAMPLE_TCL),
    .STEP_TCL  (STEP_TCL)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .hold_i    (cal_active_w),
    .scan_i    (scan_i),
    .chan_i    (chan_i),
    .stc_i     (stc_i),
    .ctc_i     (ctc_i),
    .busy_o    (busy_w),
    .busy_d_o  (busy_d_w),
    .sample_o  (sample_w),
    .step_end_o(step_end_w),
    .last_bit_o(last_bit_w),
    .bit_idx_o (bit_idx_w),
    .chan_o    (chan_w)
  );

  sar_approx_reg #(
    .RES_BITS(RES_BITS),
    .CH_W    (CH_W)
  ) u_sar (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (sample_w),
    .step_end_i    (step_end_w),
    .last_bit_i    (last_bit_w),
    .bit_idx_i     (bit_idx_w),
    .chan_i        (chan_w),
    .cmp_i         (cmp_i),
    .trial_o       (trial_o),
    .result_o      (result_o),
    .result_chan_o (result_chan_o),
    .result_valid_o(result_valid_o)
  );

  sar_power_ctl #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .off_i    (off_i),
    .busy_i   (busy_w),
    .busy_d_i (busy_d_w),
    .pwr_en_o (pwr_en_o),
    .settled_o(settled_o)
  );

  assign busy_o       = busy_w;
  assign sample_o     = sample_w;
  assign bit_strobe_o = step_end_w;
  assign chan_o       = chan_w;
  assign cal_active_o = cal_active_w;

  AST_START_BLOCKED_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active_o |=> !$rose(busy_o)); // R5
  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe_o |-> (busy_o && !sample_o)); // R3

endmodule

// File: tb/sar_adc_seq_bench.sv
module sar_adc_seq_bench;

  localparam int CLK_P  = 10;
  localparam int CAL_N  = 20;
  localparam int MHZ    = 1;
  localparam int SET_US = 12;
  localparam int SET_N  = MHZ * SET_US;

  typedef struct packed {
    logic [3:0] ch;
    logic [9:0] val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, off_i, scan_i;
  logic [3:0] chan_i;
  logic [1:0] stc_i, ctc_i;
  logic       cmp_i;
  logic       busy_o, sample_o, bit_strobe_o;
  logic [9:0] trial_o, result_o;
  logic [3:0] chan_o, result_chan_o;
  logic       result_valid_o, pwr_en_o, settled_o, cal_active_o, cal_done_o;

  logic [9:0] vin [16];
  exp_t       sb [$];
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done_flag = 1'b0;

  // run results captured by the driver
  int         r_busy, r_samp, r_strb, r_pwr_low;
  logic       r_first_settled, r_end_valid, r_end_pwr;

  always #(CLK_P/2) clk = ~clk;

  assign cmp_i = (vin[chan_o] >= trial_o);

  sar_adc_seq #(
    .CLK_MHZ   (MHZ),
    .SETTLE_US (SET_US),
    .CAL_CYCLES(CAL_N)
  ) u_sar_adc_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .off_i(off_i), .scan_i(scan_i),
    .chan_i(chan_i), .stc_i(stc_i), .ctc_i(ctc_i), .cmp_i(cmp_i),
    .busy_o(busy_o), .sample_o(sample_o), .bit_strobe_o(bit_strobe_o),
    .trial_o(trial_o), .chan_o(chan_o), .result_o(result_o),
    .result_chan_o(result_chan_o), .result_valid_o(result_valid_o),
    .pwr_en_o(pwr_en_o), .settled_o(settled_o),
    .cal_active_o(cal_active_o), .cal_done_o(cal_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: pop expected result whenever the design presents one
  always @(negedge clk) begin
    if (rst_n && result_valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 unexpected result", int'(result_o), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result_chan_o == e.ch, "R6 result channel", int'(result_chan_o), int'(e.ch));
        chk(result_o == e.val, "R4 result value", int'(result_o), int'(e.val));
      end
    end
  end

  // driver: push expectations, start, then observe the whole busy window
  task automatic run_conv(input int ch, input bit scan, input int stc, input int ctc,
                          input bit inject);
    int n_ch;
    int guard;
    n_ch = scan ? ch + 1 : 1;
    for (int c = ch; c >= (scan ? 0 : ch); c--) begin
      exp_t e;
      e.ch  = 4'(c);
      e.val = vin[c];
      sb.push_back(e);
    end
    @(negedge clk);
    chan_i  = 4'(ch);
    scan_i  = scan;
    stc_i   = 2'(stc);
    ctc_i   = 2'(ctc);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    r_first_settled = settled_o;
    r_busy = 0; r_samp = 0; r_strb = 0; r_pwr_low = 0; guard = 0;
    while (busy_o && guard < 20000) begin
      r_busy++;
      if (sample_o) r_samp++;
      if (bit_strobe_o) r_strb++;
      if (!pwr_en_o) r_pwr_low++;
      guard++;
      if (inject && r_busy == 5) begin
        start_i = 1'b1;
        chan_i  = 4'(ch ^ 1);
        scan_i  = 1'b0;
        stc_i   = 2'(~stc);
        ctc_i   = 2'(~ctc);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i     = 1'b0;
    r_end_valid = result_valid_o;
    r_end_pwr   = pwr_en_o;
    chk(r_busy == n_ch * ((8 << stc) + 40 * (1 << ctc)), "R3 busy length", r_busy,
        n_ch * ((8 << stc) + 40 * (1 << ctc)));
    chk(r_samp == n_ch * (8 << stc), "R2 sample length", r_samp, n_ch * (8 << stc));
    chk(r_strb == n_ch * 10, "R3 strobe count", r_strb, n_ch * 10);
    chk(r_end_valid == 1'b1, "R4 result with busy fall", int'(r_end_valid), 1);
    chk(r_pwr_low == 0, "R7 power during busy", r_pwr_low, 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R5 no restart after injected start", int'(busy_o), 0);
    chk(sb.size() == 0, "R6 all results seen", sb.size(), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int k;
    for (int i = 0; i < 16; i++) vin[i] = 10'((i * 341 + 7) % 1024);
    vin[0] = 10'd0;
    vin[1] = 10'd1023;
    vin[2] = 10'd512;
    vin[3] = 10'd341;
    vin[5] = 10'd682;
    vin[4] = 10'd1;

    rst_n = 1'b0; start_i = 1'b0; off_i = 1'b0; scan_i = 1'b0;
    chan_i = '0; stc_i = '0; ctc_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && sample_o == 0 && bit_strobe_o == 0 && result_valid_o == 0,
        "R1 idle outputs", int'({busy_o, sample_o, bit_strobe_o, result_valid_o}), 0);
    chk(result_o == 0, "R1 result", int'(result_o), 0);
    chk(pwr_en_o == 1 && cal_active_o == 1, "R1 power/cal", int'({pwr_en_o, cal_active_o}), 3);
    chk(cal_done_o == 0 && settled_o == 0, "R1 done/settled", int'({cal_done_o, settled_o}), 0);

    // R10 calibration length, R5 start blocked during calibration
    rst_n = 1'b1;
    k = 0;
    while (cal_active_o && k < 1000) begin
      k++;
      start_i = (k == 3);
      @(negedge clk);
      if (k == 3) chk(busy_o == 1'b0, "R5 start during calibration", int'(busy_o), 0);
    end
    start_i = 1'b0;
    chk(k == CAL_N, "R10 calibration length", k, CAL_N);
    chk(cal_done_o == 1'b1, "R10 calibration done", int'(cal_done_o), 1);
    chk(settled_o == 1'b1, "R9 settled after reset", int'(settled_o), 1);

    // conversions under several timing settings
    run_conv(3, 1'b0, 0, 0, 1'b0);
    run_conv(5, 1'b0, 3, 1, 1'b1);
    run_conv(1, 1'b0, 1, 3, 1'b0);
    run_conv(4, 1'b0, 2, 2, 1'b0);
    run_conv(0, 1'b0, 0, 1, 1'b0);
    // R6 scan walk with injected start
    run_conv(3, 1'b1, 0, 0, 1'b1);
    run_conv(5, 1'b1, 1, 0, 1'b0);

    // R8 idle power-off, R7 wake on start, R8 off again at the end
    @(negedge clk);
    off_i = 1'b1;
    @(negedge clk);
    chk(pwr_en_o == 1'b0, "R8 idle power off", int'(pwr_en_o), 0);
    chk(settled_o == 1'b0, "R9 settled low when off", int'(settled_o), 0);
    run_conv(2, 1'b0, 0, 0, 1'b0);
    chk(r_first_settled == 1'b0, "R7 starts without settling", int'(r_first_settled), 0);
    chk(r_end_pwr == 1'b0, "R8 off with busy fall", int'(r_end_pwr), 0);
    run_conv(2, 1'b1, 0, 0, 1'b0);
    chk(r_end_pwr == 1'b0, "R8 off after scan cycle", int'(r_end_pwr), 0);

    // R9 settle count after power returns
    off_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(pwr_en_o == 1'b1, "R8 power back on", int'(pwr_en_o), 1);
    k = 0;
    while (!settled_o && k < 1000) begin
      @(negedge clk);
      k++;
    end
    chk(k == SET_N, "R9 settle time", k, SET_N);

    // R11 calibration abort
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    off_i = 1'b1;
    @(negedge clk);
    off_i = 1'b0;
    chk(cal_active_o == 1'b0, "R11 calibration stopped", int'(cal_active_o), 0);
    repeat (CAL_N + 10) @(negedge clk);
    chk(cal_done_o == 1'b0, "R11 done stays low", int'(cal_done_o), 0);
    chk(cal_active_o == 1'b0, "R11 not restarted", int'(cal_active_o), 0);
    run_conv(1, 1'b0, 0, 0, 1'b0);

    report();
  end

endmodule